// File: doc/BRIEF.md
# Dual-Mode Memory Completion Reorder Buffer

This block sits between a compute pipeline that issues global memory requests and the logic that retires them. Each accepted request receives a sequence tag from the block and occupies one slot of a small tracking table until it is retired. When the memory system reports a request finished, the block records that completion. It then offers completions on a valid/ready retire port.

A mode input selects how completions are ordered. In in-order mode, a completion only marks its slot done, and the block retires the oldest outstanding request once that request is done. The result is that retirement follows issue order exactly. In arrival mode, every accepted completion is queued in a load queue or a store queue, and each queued completion carries an arrival stamp. Retirement always takes the earliest-arrived completion across both queues.

Admission is throttled. The issuer supplies a count of slots it has already promised elsewhere, and a new request is admitted only while occupancy plus that count is below the configured depth. The mode may only change while nothing is outstanding. A completion that cannot be matched to a pending request is dropped and flagged.

Top module: `mem_resp_rob`

## Requirements
- R1: After reset, `iss_ready_o` is 1 when `iss_pend_i` is 0, `iss_tag_o` is 0, `ret_valid_o` is 0, both queue write-ready outputs are 1, both error flags are 0, and the mode is in-order (`ooo_mode_i` = 0 selects in-order, 1 selects arrival order).
- R2: An issue is accepted on a cycle where `iss_valid_i` and `iss_ready_o` are both 1. It takes the tag shown on `iss_tag_o`, and the next tag is that tag plus one modulo 2*DEPTH.
- R3: `iss_ready_o` is 1 exactly when occupancy plus `iss_pend_i` is less than DEPTH. Occupancy counts the requests from the oldest unreleased one through the newest issued one. A request offered while not ready is not accepted and consumes no tag.
- R4: In in-order mode, a completion for a request that is not the oldest only marks it done. `ret_valid_o` rises the cycle after the oldest request is done, and tags retire in issue order.
- R5: While `ret_valid_o` is 1 and `ret_ready_i` is 0, `ret_valid_o` stays 1 and `ret_tag_o` and `ret_is_store_o` stay unchanged.
- R6: In arrival mode, completions retire in the order they were accepted, across loads and stores. `ret_is_store_o` gives the load/store flag that was issued with the tag (1 = store).
- R7: `ld_wr_rdy_o` and `st_wr_rdy_o` are each 1 exactly while their own completion queue holds fewer than DEPTH entries.
- R8: A change of `ooo_mode_i` takes effect only while occupancy is 0. A change made at any other time is ignored, and it sets the sticky `mode_err_o`.
- R9: A completion whose tag is not outstanding, or is already done, has no effect on retirement, and it sets the sticky `rsp_err_o`.
- R10: Retiring a request releases its slot. Once all older requests are released, the slot counts toward admission again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ooo_mode_i | input | 1 | Requested mode: 0 in-order, 1 arrival order |
| iss_valid_i | input | 1 | Issuer presents a request |
| iss_is_store_i | input | 1 | Request is a store (1) or a load (0) |
| iss_pend_i | input | PEND_W | Slots the issuer has reserved but not yet issued |
| iss_ready_o | output | 1 | Admission allowed this cycle |
| iss_tag_o | output | TAG_W | Tag given to the request accepted this cycle |
| rsp_valid_i | input | 1 | A completion arrives |
| rsp_tag_i | input | TAG_W | Tag of the completed request |
| ld_wr_rdy_o | output | 1 | Load completion queue has room |
| st_wr_rdy_o | output | 1 | Store completion queue has room |
| ret_valid_o | output | 1 | A completion is offered for retirement |
| ret_ready_i | input | 1 | Consumer takes the offered completion |
| ret_tag_o | output | TAG_W | Tag of the offered completion |
| ret_is_store_o | output | 1 | Offered completion belongs to a store |
| mode_err_o | output | 1 | Sticky: mode change attempted while busy |
| rsp_err_o | output | 1 | Sticky: unmatched or repeated completion |

## Verification
The hardest situation to reach is arrival mode with both completion queues holding entries whose arrival order interleaves loads and stores. Reaching it requires every slot to be issued with mixed flags, completions returned in an order unrelated to issue order, and the retire port held off the whole time. The bench issues alternating loads and stores and returns completions in a scrambled order with `ret_ready_i` low. It then drains the queues one retire at a time and compares each tag and store flag. A second pass fills the load queue alone to reach its full condition while the store queue stays empty.

// File: rtl/mrob_pkg.sv
package mrob_pkg;

  typedef enum logic {
    MODE_INORDER = 1'b0,
    MODE_ARRIVAL = 1'b1
  } rob_mode_e;

  localparam int unsigned SEQ_W_MAX = 16;

  // Distance from b forward to a in a w-bit wrapping number space.
  function automatic logic [SEQ_W_MAX-1:0] wrap_dist(
    input logic [SEQ_W_MAX-1:0] a,
    input logic [SEQ_W_MAX-1:0] b,
    input int unsigned          w
  );
    logic [SEQ_W_MAX-1:0] mask;
    mask = SEQ_W_MAX'((32'd1 << w) - 32'd1);
    return (a - b) & mask;
  endfunction

  // True when the load stamp is not newer than the store stamp (ties go to load).
  function automatic logic load_first(
    input logic [SEQ_W_MAX-1:0] ld_stamp,
    input logic [SEQ_W_MAX-1:0] st_stamp,
    input int unsigned          w
  );
    return wrap_dist(st_stamp, ld_stamp, w) < SEQ_W_MAX'(32'd1 << (w - 1));
  endfunction

endpackage

// File: rtl/mrob_track.sv
module mrob_track
  import mrob_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_fire,
  input  logic             iss_is_store,
  output logic [TAG_W-1:0] tail_tag,
  output logic [TAG_W-1:0] head_tag,
  output logic [TAG_W-1:0] occ,
  input  logic [TAG_W-1:0] rsp_tag,
  output logic             rsp_known,
  output logic             rsp_is_store,
  input  logic             rsp_take,
  output logic             head_done,
  output logic             head_is_store,
  input  logic             free_fire,
  input  logic [TAG_W-1:0] free_tag
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] vld_q, done_q, st_q;
  logic [TAG_W-1:0] head_q, tail_q;
  logic [IDX_W-1:0] tail_slot, head_slot, rsp_slot, free_slot;
  logic             in_window, head_adv;

  assign tail_slot = tail_q[IDX_W-1:0];
  assign head_slot = head_q[IDX_W-1:0];
  assign rsp_slot  = rsp_tag[IDX_W-1:0];
  assign free_slot = free_tag[IDX_W-1:0];

  assign occ      = tail_q - head_q;
  assign tail_tag = tail_q;
  assign head_tag = head_q;

  assign in_window = wrap_dist(SEQ_W_MAX'(rsp_tag), SEQ_W_MAX'(head_q), TAG_W)
                     < SEQ_W_MAX'(occ);
  assign rsp_known    = in_window && vld_q[rsp_slot] && !done_q[rsp_slot];
  assign rsp_is_store = st_q[rsp_slot];

  assign head_done     = (occ != '0) && vld_q[head_slot] && done_q[head_slot];
  assign head_is_store = st_q[head_slot];

  // The oldest pointer moves past a slot that is already released, or that is released now.
  assign head_adv = (occ != '0) &&
                    (!vld_q[head_slot] || (free_fire && (free_tag == head_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= '0;
      st_q   <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (rsp_take) done_q[rsp_slot] <= 1'b1;
      if (free_fire) vld_q[free_slot] <= 1'b0;
      if (iss_fire) begin
        vld_q[tail_slot]  <= 1'b1;
        done_q[tail_slot] <= 1'b0;
        st_q[tail_slot]   <= iss_is_store;
        tail_q            <= tail_q + 1'b1;
      end
      if (head_adv) head_q <= head_q + 1'b1;
    end
  end

endmodule

// File: rtl/mrob_rsp_fifo.sv
module mrob_rsp_fifo #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [TAG_W-1:0] push_stamp,
  input  logic             pop,
  output logic             nonempty,
  output logic [TAG_W-1:0] head_tag,
  output logic [TAG_W-1:0] head_stamp,
  output logic             wr_rdy
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [TAG_W-1:0] tag_mem   [DEPTH];
  logic [TAG_W-1:0] stamp_mem [DEPTH];
  logic [IDX_W:0]   wr_q, rd_q, fill;

  assign fill       = wr_q - rd_q;
  assign nonempty   = (fill != '0);
  assign wr_rdy     = fill < (IDX_W+1)'(DEPTH);
  assign head_tag   = tag_mem[rd_q[IDX_W-1:0]];
  assign head_stamp = stamp_mem[rd_q[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_mem[i]   <= '0;
        stamp_mem[i] <= '0;
      end
    end else begin
      if (push && wr_rdy) begin
        tag_mem[wr_q[IDX_W-1:0]]   <= push_tag;
        stamp_mem[wr_q[IDX_W-1:0]] <= push_stamp;
        wr_q <= wr_q + 1'b1;
      end
      if (pop && nonempty) rd_q <= rd_q + 1'b1;
    end
  end

endmodule

// File: rtl/mrob_ret_sel.sv
module mrob_ret_sel
  import mrob_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             ld_vld,
  input  logic [TAG_W-1:0] ld_stamp,
  input  logic             st_vld,
  input  logic [TAG_W-1:0] st_stamp,
  output logic             take_ld
);

  assign take_ld = ld_vld &&
                   (!st_vld || load_first(SEQ_W_MAX'(ld_stamp), SEQ_W_MAX'(st_stamp), TAG_W));

endmodule

// File: rtl/mem_resp_rob.sv
module mem_resp_rob
  import mrob_pkg::*;
#(
  parameter  int DEPTH  = 4,
  parameter  int PEND_W = 3,
  localparam int TAG_W  = $clog2(2 * DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ooo_mode_i,
  input  logic              iss_valid_i,
  input  logic              iss_is_store_i,
  input  logic [PEND_W-1:0] iss_pend_i,
  output logic              iss_ready_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  output logic              ld_wr_rdy_o,
  output logic              st_wr_rdy_o,
  output logic              ret_valid_o,
  input  logic              ret_ready_i,
  output logic [TAG_W-1:0]  ret_tag_o,
  output logic              ret_is_store_o,
  output logic              mode_err_o,
  output logic              rsp_err_o
);

  rob_mode_e        mode_q;
  logic [TAG_W-1:0] occ, head_tag, tail_tag, stamp_q;
  logic [TAG_W-1:0] ld_tag, st_tag, ld_stamp, st_stamp;
  logic             iss_fire, rsp_known, rsp_is_store, rsp_room, rsp_take, rsp_bad;
  logic             head_done, head_is_store, ret_fire, mode_bad, in_order;
  logic             ld_push, st_push, ld_pop, st_pop, ld_ne, st_ne, take_ld;
  logic             mode_err_q, rsp_err_q;

  assign in_order = (mode_q == MODE_INORDER);

  // Admission: occupancy plus promised slots must stay under the depth.
  assign iss_ready_o = (32'(occ) + 32'(iss_pend_i)) < 32'(DEPTH);
  assign iss_fire    = iss_valid_i && iss_ready_o;
  assign iss_tag_o   = tail_tag;

  assign rsp_room = in_order || (rsp_is_store ? st_wr_rdy_o : ld_wr_rdy_o);
  assign rsp_take = rsp_valid_i && rsp_known && rsp_room;
  assign rsp_bad  = rsp_valid_i && !rsp_take;
  assign ld_push  = rsp_take && !in_order && !rsp_is_store;
  assign st_push  = rsp_take && !in_order && rsp_is_store;

  assign mode_bad = (rob_mode_e'(ooo_mode_i) != mode_q) && (occ != '0);

  mrob_track #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .iss_fire     (iss_fire),
    .iss_is_store (iss_is_store_i),
    .tail_tag     (tail_tag),
    .head_tag     (head_tag),
    .occ          (occ),
    .rsp_tag      (rsp_tag_i),
    .rsp_known    (rsp_known),
    .rsp_is_store (rsp_is_store),
    .rsp_take     (rsp_take),
    .head_done    (head_done),
    .head_is_store(head_is_store),
    .free_fire    (ret_fire),
    .free_tag     (ret_tag_o)
  );

  mrob_rsp_fifo #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ld_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ld_push),
    .push_tag  (rsp_tag_i),
    .push_stamp(stamp_q),
    .pop       (ld_pop),
    .nonempty  (ld_ne),
    .head_tag  (ld_tag),
    .head_stamp(ld_stamp),
    .wr_rdy    (ld_wr_rdy_o)
  );

  mrob_rsp_fifo #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_st_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (st_push),
    .push_tag  (rsp_tag_i),
    .push_stamp(stamp_q),
    .pop       (st_pop),
    .nonempty  (st_ne),
    .head_tag  (st_tag),
    .head_stamp(st_stamp),
    .wr_rdy    (st_wr_rdy_o)
  );

  mrob_ret_sel #(.TAG_W(TAG_W)) u_sel (
    .ld_vld  (ld_ne),
    .ld_stamp(ld_stamp),
    .st_vld  (st_ne),
    .st_stamp(st_stamp),
    .take_ld (take_ld)
  );

  assign ret_valid_o    = in_order ? head_done     : (ld_ne || st_ne);
  assign ret_tag_o      = in_order ? head_tag      : (take_ld ? ld_tag : st_tag);
  assign ret_is_store_o = in_order ? head_is_store : !take_ld;
  assign ret_fire       = ret_valid_o && ret_ready_i;
  assign ld_pop         = ret_fire && !in_order && take_ld;
  assign st_pop         = ret_fire && !in_order && !take_ld;

  assign mode_err_o = mode_err_q;
  assign rsp_err_o  = rsp_err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MODE_INORDER;
      stamp_q    <= '0;
      mode_err_q <= 1'b0;
      rsp_err_q  <= 1'b0;
    end else begin
      if (occ == '0) mode_q <= rob_mode_e'(ooo_mode_i);
      if (ld_push || st_push) stamp_q <= stamp_q + 1'b1;
      if (mode_bad) mode_err_q <= 1'b1;
      if (rsp_bad) rsp_err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mem_resp_rob_chk.sv
module mem_resp_rob_chk #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_fire,
  input logic [TAG_W-1:0] occ,
  input logic             mode_q,
  input logic             ret_valid,
  input logic             ret_ready,
  input logic [TAG_W-1:0] ret_tag,
  input logic             ret_is_store,
  input logic             rsp_err,
  input logic             mode_err
);

  p_admit_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |-> (32'(occ) < 32'(DEPTH)));

  p_ret_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> (ret_valid && $stable(ret_tag) && $stable(ret_is_store)));

  p_ret_needs_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (occ != '0));

  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0) |=> $stable(mode_q));

  p_mode_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);

  p_rsp_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> rsp_err);

endmodule

bind mem_resp_rob mem_resp_rob_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .iss_fire    (iss_fire),
  .occ         (occ),
  .mode_q      (mode_q),
  .ret_valid   (ret_valid_o),
  .ret_ready   (ret_ready_i),
  .ret_tag     (ret_tag_o),
  .ret_is_store(ret_is_store_o),
  .rsp_err     (rsp_err_o),
  .mode_err    (mode_err_o)
);

// File: tb/mem_resp_rob_bench.sv
`timescale 1ns/1ps
module mem_resp_rob_bench;

  localparam int DEPTH  = 4;
  localparam int PEND_W = 3;
  localparam int TAG_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ooo_mode_i = 1'b0;
  logic              iss_valid_i = 1'b0;
  logic              iss_is_store_i = 1'b0;
  logic [PEND_W-1:0] iss_pend_i = '0;
  logic              iss_ready_o;
  logic [TAG_W-1:0]  iss_tag_o;
  logic              rsp_valid_i = 1'b0;
  logic [TAG_W-1:0]  rsp_tag_i = '0;
  logic              ld_wr_rdy_o, st_wr_rdy_o;
  logic              ret_valid_o;
  logic              ret_ready_i = 1'b0;
  logic [TAG_W-1:0]  ret_tag_o;
  logic              ret_is_store_o;
  logic              mode_err_o, rsp_err_o;

  always #2.5 clk = ~clk;

  mem_resp_rob #(.DEPTH(DEPTH), .PEND_W(PEND_W)) u_mem_resp_rob (.*);

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic reset_dut(input logic mode);
    iss_valid_i = 0; rsp_valid_i = 0; ret_ready_i = 0; iss_pend_i = '0;
    ooo_mode_i = mode;
    rst_n = 0;
    repeat (2) cyc();
    rst_n = 1;
    repeat (2) cyc();
  endtask

  task automatic issue_one(input logic st);
    iss_valid_i = 1; iss_is_store_i = st;
    cyc();
    iss_valid_i = 0;
  endtask

  task automatic respond(input logic [TAG_W-1:0] t);
    rsp_valid_i = 1; rsp_tag_i = t;
    cyc();
    rsp_valid_i = 0;
  endtask

  // Table-driven in-order pass: inputs for one cycle and the outputs expected before its edge.
  typedef struct packed {
    logic       iv;
    logic       ist;
    logic       rv;
    logic [2:0] rtag;
    logic       rr;
    logic       erv;
    logic [2:0] etag;
    logic       eist;
    logic [2:0] eitag;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0},
    '{1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd1},
    '{1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd2},
    '{1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 1'b0, 3'd3},
    '{1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd3},
    '{1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd3},
    '{1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 3'd0, 1'b0, 3'd3},
    '{1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 1'b0, 3'd0, 1'b0, 3'd3},
    '{1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd3},
    '{1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 3'd1, 1'b1, 3'd3},
    '{1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b1, 3'd2, 1'b0, 3'd3},
    '{1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd3}
  };

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    reset_dut(1'b0);

    // R1 reset state
    chk("R1 iss_ready", iss_ready_o, 1);
    chk("R1 iss_tag", iss_tag_o, 0);
    chk("R1 ret_valid", ret_valid_o, 0);
    chk("R1 ld_wr_rdy", ld_wr_rdy_o, 1);
    chk("R1 st_wr_rdy", st_wr_rdy_o, 1);
    chk("R1 mode_err", mode_err_o, 0);
    chk("R1 rsp_err", rsp_err_o, 0);

    // R4 / R5 / R2 table walk
    foreach (VEC[k]) begin
      iss_valid_i = VEC[k].iv; iss_is_store_i = VEC[k].ist;
      rsp_valid_i = VEC[k].rv; rsp_tag_i = VEC[k].rtag;
      ret_ready_i = VEC[k].rr;
      #1;
      chk("R2 table iss_tag", iss_tag_o, VEC[k].eitag);
      chk("R3 table iss_ready", iss_ready_o, 1);
      chk("R4 table ret_valid", ret_valid_o, VEC[k].erv);
      if (VEC[k].erv) begin
        chk("R4 R5 table ret_tag", ret_tag_o, VEC[k].etag);
        chk("R4 table ret_is_store", ret_is_store_o, VEC[k].eist);
      end
      @(posedge clk);
      #1;
    end
    iss_valid_i = 0; rsp_valid_i = 0; ret_ready_i = 0;

    // R3 admission with reservations, R10 release, R2 wrap
    reset_dut(1'b0);
    issue_one(0); issue_one(0);
    iss_pend_i = 3'd2; #1;
    chk("R3 pend=2 blocks", iss_ready_o, 0);
    iss_pend_i = 3'd1; #1;
    chk("R3 pend=1 admits", iss_ready_o, 1);
    iss_pend_i = 3'd0;
    issue_one(1); issue_one(0);
    chk("R3 full", iss_ready_o, 0);
    issue_one(0);
    chk("R3 refused issue takes no tag", iss_tag_o, 4);
    ret_ready_i = 1;
    for (int t = 0; t < 4; t++) begin
      respond(3'(t));
      chk("R4 retire tag", ret_tag_o, 32'(t));
      chk("R4 retire valid", ret_valid_o, 1);
      cyc();
    end
    ret_ready_i = 0;
    chk("R10 released slots admit", iss_ready_o, 1);
    ret_ready_i = 1;
    for (int t = 4; t < 8; t++) begin
      issue_one(0);
      respond(3'(t));
      cyc();
    end
    ret_ready_i = 0;
    chk("R2 tag wraps to 0", iss_tag_o, 0);
    chk("R10 empty after retire", ret_valid_o, 0);

    // R9 unmatched and repeated completions
    reset_dut(1'b0);
    respond(3'd5);
    chk("R9 unmatched sets err", rsp_err_o, 1);
    chk("R9 unmatched no retire", ret_valid_o, 0);
    reset_dut(1'b0);
    issue_one(1);
    respond(3'd0);
    chk("R9 first completion clean", rsp_err_o, 0);
    respond(3'd0);
    chk("R9 repeat sets err", rsp_err_o, 1);
    chk("R9 repeat keeps offer", ret_tag_o, 0);
    cyc();
    chk("R9 err sticky", rsp_err_o, 1);

    // R8 mode change while busy is ignored
    reset_dut(1'b0);
    issue_one(0);
    ooo_mode_i = 1;
    cyc();
    chk("R8 busy change flags", mode_err_o, 1);
    issue_one(0);
    respond(3'd1);
    chk("R8 still in-order", ret_valid_o, 0);
    ret_ready_i = 1;
    respond(3'd0);
    chk("R8 oldest retires", ret_tag_o, 0);
    cyc();
    chk("R8 next retires", ret_tag_o, 1);
    cyc();
    ret_ready_i = 0;

    // R6 arrival order across loads and stores
    reset_dut(1'b1);
    issue_one(0); issue_one(1); issue_one(0); issue_one(1);
    respond(3'd3); respond(3'd0); respond(3'd2); respond(3'd1);
    chk("R7 ld room", ld_wr_rdy_o, 1);
    chk("R7 st room", st_wr_rdy_o, 1);
    chk("R6 offer valid", ret_valid_o, 1);
    ret_ready_i = 1;
    begin
      logic [2:0] exp_tag [4];
      logic       exp_st  [4];
      exp_tag = '{3'd3, 3'd0, 3'd2, 3'd1};
      exp_st  = '{1'b1, 1'b0, 1'b0, 1'b1};
      for (int i = 0; i < 4; i++) begin
        chk("R6 arrival tag", ret_tag_o, 32'(exp_tag[i]));
        chk("R6 store flag", ret_is_store_o, 32'(exp_st[i]));
        cyc();
      end
    end
    ret_ready_i = 0;
    repeat (6) cyc();
    chk("R10 arrival slots released", iss_ready_o, 1);
    chk("R2 next tag", iss_tag_o, 4);

    // R7 load queue fills while store queue stays empty
    for (int i = 0; i < 4; i++) issue_one(0);
    respond(3'd7); respond(3'd5); respond(3'd4); respond(3'd6);
    chk("R7 ld queue full", ld_wr_rdy_o, 0);
    chk("R7 st queue free", st_wr_rdy_o, 1);
    ret_ready_i = 1;
    begin
      logic [2:0] exp_tag2 [4];
      exp_tag2 = '{3'd7, 3'd5, 3'd4, 3'd6};
      for (int i = 0; i < 4; i++) begin
        chk("R6 load arrival tag", ret_tag_o, 32'(exp_tag2[i]));
        cyc();
      end
    end
    chk("R7 ld queue drained", ld_wr_rdy_o, 1);
    ret_ready_i = 0;

    finish_run();
  end

endmodule